// File: doc/BRIEF.md
# Dual-Rate Energy Voice Activity Detector

This block watches a stream of signed 16-bit audio samples, already decimated and filtered upstream, and decides whether someone is speaking. Each sample that arrives with its valid strobe updates two smoothed magnitude estimates. The short-term estimate reacts quickly and follows the instantaneous loudness. The long-term estimate moves slowly and follows the background level. Each estimate's response speed comes from its own attack field, and a larger field value gives a faster response.

The long-term estimate has a programmable floor for the decision. The margin of the short-term power over that floored background is the deviation. Speech starts when the short-term power is above an upper threshold and the deviation is above a deviation threshold. Speech ends only when the short-term power falls below a separate lower threshold. After that, the talk indication stays high for a programmable number of further samples. Every entry into speech also sets a sticky flag, which stays set until a clear pulse removes it.

The decision is a three-state machine:
- `DS_IDLE`: no speech.
- `DS_TALK`: speech detected.
- `DS_HOLD`: the hang-over period after speech.

Its transitions are:
- start: `DS_IDLE` to `DS_TALK` on a trigger.
- release: `DS_TALK` to `DS_HOLD` when the short-term power drops below the lower threshold and the hang count is non-zero.
- quick release: `DS_TALK` to `DS_IDLE` on the same drop when the hang count is zero.
- resume: `DS_HOLD` to `DS_TALK` on a trigger.
- expire: `DS_HOLD` to `DS_IDLE` when the hang-over count runs out.

Top module: `voice_energy_detector`

## Requirements
- R1: After reset, `st_pow`, `lt_pow` and `dev_pow` are 0, and `talk_now` and `voice_flag` are 0.
- R2: On a valid sample, the short-term power becomes `p + ((m - p) >>> k)`, where `m` is the sample magnitude and the shift is arithmetic with a floored result. The shift `k` is the upper 4 bits of the bitwise inverse of `fast_rate`, so 0xAA gives 5 and 0xFF gives 0. The result is saturated to the range 0 to 65535.
- R3: The long-term power uses the same update with `k = 15 - slow_rate`, so 5 gives 10.
- R4: While `smp_valid` is 0, the powers, the state and the hang-over count do not change.
- R5: The effective background is `max(lt_pow, floor_thr)`. `dev_pow` is `st_pow` minus that background when `st_pow` is larger, and 0 otherwise. `lt_pow` always shows the raw, unfloored estimate.
- R6: On a valid sample in `DS_IDLE` or `DS_HOLD`, the state goes to `DS_TALK` when `st_pow > st_hi_thr` and `dev_pow > dev_thr`, both compared strictly, using the values shown on the ports before that clock edge.
- R7: In `DS_TALK`, a valid sample leaves the state unchanged while `st_pow >= st_lo_thr`. A valid sample with `st_pow < st_lo_thr` ends speech.
- R8: When speech ends, `talk_now` stays 1 for `hang_len` further valid samples that do not trigger. With `hang_len = 0` the state returns to idle at once. `talk_now` is 1 in `DS_TALK` and `DS_HOLD`.
- R9: Every entry into `DS_TALK` sets `voice_flag`. The flag then stays 1 until a `flag_clr` pulse, and that clear acts on any cycle, whether or not a sample is valid.
- R10: When a clear pulse falls in the same cycle as an entry into `DS_TALK`, `voice_flag` is left at 1.
- R11: The sample magnitude of -32768 is 32768, and it passes unclipped into the estimates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed audio sample |
| fast_rate | input | 8 | Short-term attack field (larger is faster) |
| slow_rate | input | 4 | Long-term attack field (larger is faster) |
| st_hi_thr | input | 16 | Short-term start threshold |
| st_lo_thr | input | 16 | Short-term end threshold |
| floor_thr | input | 16 | Background floor used for the decision |
| dev_thr | input | 16 | Deviation threshold |
| hang_len | input | 16 | Hang-over length in valid samples |
| flag_clr | input | 1 | Clear pulse for the sticky flag |
| st_pow | output | 16 | Short-term power |
| lt_pow | output | 16 | Long-term power (raw) |
| dev_pow | output | 16 | Deviation over the floored background |
| talk_now | output | 1 | Speech or hang-over in progress |
| voice_flag | output | 1 | Sticky speech-detected flag |

## Verification
The bench targets the corner cases most likely to hide a fault:
- A clear pulse that falls in the same cycle as a speech entry. A design that lets the clear win would lose the event.
- A sample of -32768 with the fastest attack setting. A magnitude stage that wraps would report 0 instead of 32768.
- A background floor above the raw estimate. A design that floors the readback, or forgets the floor, would show a wrong `lt_pow` or a non-zero deviation.
- Hang-over counts of zero and three with non-valid cycles inside the window. An off-by-one counter, or one that counts clocks instead of samples, would drop `talk_now` a sample early or late.

Random sample bursts under changing settings are then compared against a bench model.

// File: rtl/vde_pkg.sv
package vde_pkg;

    // Width of the smoothing shift derived from an attack field
    localparam int SHIFT_W = 4;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_TALK = 2'd1,
        DS_HOLD = 2'd2
    } det_state_e;

endpackage

// File: rtl/vde_power_track.sv
module vde_power_track #(
    parameter int DW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [DW-1:0] mag,
    input  logic [RW-1:0] rate,
    output logic [DW-1:0] pwr
);
    localparam int KW = vde_pkg::SHIFT_W;
    localparam logic signed [DW+1:0] PMAX = {2'b00, {DW{1'b1}}};

    logic [RW-1:0]          rate_inv;
    logic [KW-1:0]          k;
    logic signed [DW+1:0]   diff;
    logic signed [DW+1:0]   step;
    logic signed [DW+1:0]   sum;
    logic [DW-1:0]          nxt;

    assign rate_inv = ~rate;

    generate
        if (RW >= KW) begin : g_wide
            assign k = KW'(rate_inv >> (RW - KW));
        end else begin : g_narrow
            assign k = KW'(rate_inv);
        end
    endgenerate

    always_comb begin
        diff = $signed({2'b00, mag}) - $signed({2'b00, pwr});
        step = diff >>> k;
        sum  = $signed({2'b00, pwr}) + step;
        if (sum < 0)
            nxt = '0;
        else if (sum > PMAX)
            nxt = {DW{1'b1}};
        else
            nxt = sum[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pwr <= '0;
        else if (valid)
            pwr <= nxt;
    end

    // R4: estimate frozen between samples
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(pwr));
    // R2 / R3: a rising step never overshoots the magnitude
    a_r2_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mag >= pwr) |=> (pwr >= $past(pwr) && pwr <= $past(mag)));
    // R3 / R2: a falling step never undershoots the magnitude
    a_r3_fall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mag < pwr) |=> (pwr <= $past(pwr) && pwr >= $past(mag)));

endmodule

// File: rtl/vde_decide.sv
module vde_decide #(
    parameter int DW = 16,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          clr,
    input  logic [DW-1:0] st_pow,
    input  logic [DW-1:0] lt_pow,
    input  logic [DW-1:0] hi_thr,
    input  logic [DW-1:0] lo_thr,
    input  logic [DW-1:0] floor_thr,
    input  logic [DW-1:0] dev_thr,
    input  logic [HW-1:0] hang_len,
    output logic [DW-1:0] dev_pow,
    output logic          talk_now,
    output logic          voice_flag
);
    import vde_pkg::*;

    localparam logic [HW-1:0] ONE = {{(HW-1){1'b0}}, 1'b1};

    det_state_e    state, nxt;
    logic [HW-1:0] cnt;
    logic [DW-1:0] bg_eff;
    logic          trigger, release_c, load, dec, enter;

    always_comb begin
        bg_eff    = (lt_pow < floor_thr) ? floor_thr : lt_pow;
        dev_pow   = (st_pow > bg_eff) ? (st_pow - bg_eff) : '0;
        trigger   = (st_pow > hi_thr) && (dev_pow > dev_thr);
        release_c = (st_pow < lo_thr);
    end

    // next-state logic
    always_comb begin
        nxt  = state;
        load = 1'b0;
        dec  = 1'b0;
        if (valid) begin
            unique case (state)
                DS_IDLE: if (trigger) nxt = DS_TALK;
                DS_TALK: begin
                    if (release_c) begin
                        if (hang_len == '0) begin
                            nxt = DS_IDLE;
                        end else begin
                            nxt  = DS_HOLD;
                            load = 1'b1;
                        end
                    end
                end
                DS_HOLD: begin
                    if (trigger)
                        nxt = DS_TALK;
                    else if (cnt <= ONE)
                        nxt = DS_IDLE;
                    else
                        dec = 1'b1;
                end
                default: nxt = DS_IDLE;
            endcase
        end
    end

    assign enter = (state != DS_TALK) && (nxt == DS_TALK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= DS_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= hang_len;
        else if (dec)
            cnt <= cnt - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            voice_flag <= 1'b0;
        else
            voice_flag <= enter | (voice_flag & ~clr);
    end

    // outputs
    always_comb begin
        talk_now = (state != DS_IDLE);
    end

    // R9: flag stays set without a clear
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (voice_flag && !clr) |=> voice_flag);
    // R10: entry beats a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && state == DS_IDLE && trigger) |=> (voice_flag && state == DS_TALK));
    // R7: hysteresis keeps speech while above the lower threshold
    a_r7_hold_talk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && state == DS_TALK && !release_c) |=> state == DS_TALK);
    // R4: hang-over does not advance without a sample
    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && state == DS_HOLD) |=> (state == DS_HOLD && $stable(cnt)));
    // R5: deviation never exceeds the short-term power
    a_r5_dev_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pow <= st_pow);

endmodule

// File: rtl/voice_energy_detector.sv
module voice_energy_detector #(
    parameter int DW     = 16,
    parameter int FAST_W = 8,
    parameter int SLOW_W = 4,
    parameter int HW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DW-1:0]     smp_data,
    input  logic [FAST_W-1:0] fast_rate,
    input  logic [SLOW_W-1:0] slow_rate,
    input  logic [DW-1:0]     st_hi_thr,
    input  logic [DW-1:0]     st_lo_thr,
    input  logic [DW-1:0]     floor_thr,
    input  logic [DW-1:0]     dev_thr,
    input  logic [HW-1:0]     hang_len,
    input  logic              flag_clr,
    output logic [DW-1:0]     st_pow,
    output logic [DW-1:0]     lt_pow,
    output logic [DW-1:0]     dev_pow,
    output logic              talk_now,
    output logic              voice_flag
);
    logic [DW-1:0] mag;

    // R11: two's complement negate; the most negative code maps to 2^(DW-1)
    assign mag = smp_data[DW-1] ? (~smp_data + 1'b1) : smp_data;

    vde_power_track #(.DW(DW), .RW(FAST_W)) u_short (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (smp_valid),
        .mag   (mag),
        .rate  (fast_rate),
        .pwr   (st_pow)
    );

    vde_power_track #(.DW(DW), .RW(SLOW_W)) u_long (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (smp_valid),
        .mag   (mag),
        .rate  (slow_rate),
        .pwr   (lt_pow)
    );

    vde_decide #(.DW(DW), .HW(HW)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (smp_valid),
        .clr        (flag_clr),
        .st_pow     (st_pow),
        .lt_pow     (lt_pow),
        .hi_thr     (st_hi_thr),
        .lo_thr     (st_lo_thr),
        .floor_thr  (floor_thr),
        .dev_thr    (dev_thr),
        .hang_len   (hang_len),
        .dev_pow    (dev_pow),
        .talk_now   (talk_now),
        .voice_flag (voice_flag)
    );

    // R1 / R11: magnitude is never negative-wrapped
    a_r11_mag_range: assert property (@(posedge clk) disable iff (!rst_n)
        mag <= {1'b1, {(DW-1){1'b0}}});

endmodule

// File: tb/test_voice_energy_detector.sv
module test_voice_energy_detector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [7:0]  fast_rate = 8'hAA;
    logic [3:0]  slow_rate = 4'h5;
    logic [15:0] st_hi_thr = '0, st_lo_thr = '0, floor_thr = '0, dev_thr = '0, hang_len = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] st_pow, lt_pow, dev_pow;
    logic        talk_now, voice_flag;

    int checks = 0, errors = 0;
    int m_st, m_lt, m_state, m_cnt, m_flag;   // model state: 0 idle, 1 talk, 2 hold

    always #(CLK_PERIOD/2) clk = ~clk;

    voice_energy_detector i_voice_energy_detector (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .fast_rate(fast_rate), .slow_rate(slow_rate), .st_hi_thr(st_hi_thr),
        .st_lo_thr(st_lo_thr), .floor_thr(floor_thr), .dev_thr(dev_thr),
        .hang_len(hang_len), .flag_clr(flag_clr), .st_pow(st_pow), .lt_pow(lt_pow),
        .dev_pow(dev_pow), .talk_now(talk_now), .voice_flag(voice_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int f_upd(input int p, input int m, input int k);
        int s;
        s = p + ((m - p) >>> k);
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        return s;
    endfunction

    function automatic int f_dev(input int st, input int lt);
        int eff;
        eff = (lt < int'(floor_thr)) ? int'(floor_thr) : lt;
        return (st > eff) ? st - eff : 0;
    endfunction

    task automatic model_next(input logic v, input int s, input logic c);
        int mag, dv, nst, enter;
        logic trig, rel;
        mag   = (s < 0) ? -s : s;
        dv    = f_dev(m_st, m_lt);
        trig  = (m_st > int'(st_hi_thr)) && (dv > int'(dev_thr));
        rel   = m_st < int'(st_lo_thr);
        nst   = m_state;
        enter = 0;
        if (v) begin
            case (m_state)
                0: if (trig) nst = 1;
                1: if (rel) begin
                       if (hang_len == 0) nst = 0;
                       else begin nst = 2; m_cnt = int'(hang_len); end
                   end
                default: begin
                    if (trig) nst = 1;
                    else if (m_cnt <= 1) nst = 0;
                    else m_cnt = m_cnt - 1;
                end
            endcase
            enter = (m_state != 1 && nst == 1) ? 1 : 0;
            m_st  = f_upd(m_st, mag, int'((8'hFF - fast_rate) >> 4));
            m_lt  = f_upd(m_lt, mag, 15 - int'(slow_rate));
        end
        m_state = nst;
        m_flag  = (enter != 0 || (m_flag != 0 && !c)) ? 1 : 0;
    endtask

    task automatic compare_all();
        chk("R2 st_pow", int'(st_pow), m_st);
        chk("R3 lt_pow", int'(lt_pow), m_lt);
        chk("R5 dev_pow", int'(dev_pow), f_dev(m_st, m_lt));
        chk("R8 talk_now", int'(talk_now), (m_state != 0) ? 1 : 0);
        chk("R9 voice_flag", int'(voice_flag), m_flag);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic v, input int s, input logic c);
        smp_valid = v;
        smp_data  = s[15:0];
        flag_clr  = c;
        model_next(v, s, c);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        flag_clr  = 1'b0;
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0;
        flag_clr = 1'b0;
        m_st = 0; m_lt = 0; m_state = 0; m_cnt = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk("R1 st_pow", int'(st_pow), 0);
        chk("R1 lt_pow", int'(lt_pow), 0);
        chk("R1 dev_pow", int'(dev_pow), 0);
        chk("R1 talk_now", int'(talk_now), 0);
        chk("R1 voice_flag", int'(voice_flag), 0);

        // default rates: k=5 short, k=10 long
        step(1, 4000, 0);
        chk("R2 default", int'(st_pow), 125);
        chk("R3 default", int'(lt_pow), 3);
        // R4 no sample, no change
        step(0, 30000, 0);
        chk("R4 st hold", int'(st_pow), 125);

        // directed hysteresis / hang / collision
        do_reset();
        fast_rate = 8'hFF; slow_rate = 4'h0;
        st_hi_thr = 500; st_lo_thr = 200; dev_thr = 100; floor_thr = 0; hang_len = 3;
        step(1, 1000, 0);
        chk("R2 k0", int'(st_pow), 1000);
        step(1, -1000, 1);
        chk("R10 set wins", int'(voice_flag), 1);
        chk("R6 start", int'(talk_now), 1);
        step(1, 300, 0);
        step(1, 300, 0);
        chk("R7 above lo", int'(talk_now), 1);
        step(1, 0, 0);
        step(1, 0, 0);
        chk("R8 hold entry", int'(talk_now), 1);
        step(0, 0, 0);
        step(0, 0, 0);
        chk("R4 hold frozen", int'(talk_now), 1);
        step(1, 0, 0);
        step(1, 0, 0);
        chk("R8 second hang sample", int'(talk_now), 1);
        step(1, 0, 0);
        chk("R8 expired", int'(talk_now), 0);
        chk("R9 sticky", int'(voice_flag), 1);
        step(0, 0, 1);
        chk("R9 clear", int'(voice_flag), 0);

        // floor clamp
        floor_thr = 2000;
        step(1, 1500, 0);
        chk("R5 floored dev", int'(dev_pow), 0);
        chk("R5 raw lt", int'(lt_pow), 0);
        step(1, 1500, 0);
        chk("R6 no trigger", int'(talk_now), 0);
        floor_thr = 1000;
        #1;
        chk("R5 dev over floor", int'(dev_pow), 500);
        step(1, 1500, 0);
        chk("R6 trigger", int'(talk_now), 1);
        hang_len = 0;
        step(1, 0, 0);
        step(1, 0, 0);
        chk("R8 zero hang", int'(talk_now), 0);

        // most negative sample with fastest rates
        fast_rate = 8'hFF; slow_rate = 4'hF;
        step(1, -32768, 0);
        chk("R11 st", int'(st_pow), 32768);
        chk("R11 lt", int'(lt_pow), 32768);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            int amp, s;
            if (n % 200 == 0) begin
                fast_rate = 8'(8'h80 + ($urandom % 128));
                slow_rate = 4'($urandom % 9);
                st_hi_thr = 16'(500 + ($urandom % 7500));
                st_lo_thr = st_hi_thr >> 1;
                dev_thr   = 16'($urandom % 4000);
                floor_thr = 16'($urandom % 3000);
                hang_len  = 16'($urandom % 9);
            end
            amp = ((n / 64) % 2 == 1) ? 20000 : 300;
            s   = int'($urandom % (amp + 1));
            if ($urandom % 2 == 1) s = -s;
            step(($urandom % 4) != 0, s, ($urandom % 50) == 0);
        end

        finish_run();
    end

endmodule